// File: doc/BRIEF.md
# Memory-Mapped Debug Log Port

This block is a bus slave that gives running software a way to send text log lines to the outside world. It decodes single-cycle 16-bit reads and writes within a small register window. The window holds three things. The first is a lock register that opens only when software writes a fixed key. The second is a control word that carries a severity code and a send bit. The third is a 256-byte text area that software fills two bytes per write.

When software sets the send bit with the port open and a legal severity code, the block plays the stored text out on a valid/ready byte stream. Each byte carries a three-bit severity tag, and the final byte of the message carries a last marker. The block then wipes the text area one word per cycle and returns to idle. While it is streaming or wiping, it raises busy and holds off bus writes to the text area and to the control word. A send request with an illegal severity code emits nothing. Instead it sets a sticky error bit that software can read back.

Top module: `dbglog_port`

## Requirements
- R1: A write of exactly 0xC0DE to offset 0x780 opens the port, and a write of any other value to 0x780 closes it. Reading 0x780 returns 0x1DEA while the port is open and 0x0000 while it is closed. Writes to 0x780 are never held off.
- R2: A read of offset 0x700 returns the sticky error flag in bit 15 and zeros in all other bits. A read of the text area (0x600 to 0x6FF) or of any other offset returns 0x0000. The port comes out of reset closed, idle, with the error flag clear and the text area all zero.
- R3: A write at text offset N (bus offset 0x600+N) stores data bits 7:0 at byte N and data bits 15:8 at byte N+1. When N is 255, the high byte is discarded. Text writes take effect whether the port is open or closed.
- R4: While the port is closed, a write to 0x700 has no effect, even when the send bit is set.
- R5: A write to 0x700 with bit 8 set and a legal code in bits 3:0 starts a message while the port is open. The message is the bytes from index 0 upward, in order, up to but not including the first zero byte, with at most 256 bytes. out_last is high only on the final byte. If byte 0 is zero, the message has no bytes at all.
- R6: The tag on out_sev is 1 (error) for codes 0 and 1, 2 (warning) for code 2, 3 (info) for code 3, and 4 (debug) for code 4.
- R7: A send request with a code above 4 emits nothing and leaves busy low. It sets the error flag, which stays set until reset.
- R8: A write to 0x700 with bit 8 clear emits nothing and leaves busy low.
- R9: busy is high from the cycle after a send is accepted until the wipe ends. While busy is high, writes to the text area or to 0x700 are held with bus_wait, and reads are never held.
- R10: Once the final byte is accepted, or at once for an empty message, the text area is cleared to zero over 128 cycles, one word per cycle. After that, busy drops. A new send without fresh text emits nothing.
- R11: While out_valid is high and out_ready is low, out_valid, out_data, out_sev and out_last stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the peripheral |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of a read |
| bus_wait | output | 1 | Write is held; the master keeps it on the bus |
| busy | output | 1 | Message streaming or text area wiping |
| out_valid | output | 1 | Stream byte present |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Stream byte |
| out_sev | output | 3 | Severity tag of the message |
| out_last | output | 1 | Final byte of the message |

## Verification
Two things can meet while a message is in progress: a bus write that must be held off, and the stream or the wipe itself. The bench starts a long message with a sink that stalls on a fixed pattern. It then writes the lock register, which must go through at once, and queues a text write, which must be held. That text write lands in the first cycle after the wipe ends. If it lands too early, the wipe erases it; if the hold ends early, it disturbs the message. Either fault shows in the next message or in the per-cycle comparison of busy and bus_wait against the reference model.

// File: rtl/dbglog_port.sv
module dbglog_port #(
  parameter int ADDR_W      = 12,
  parameter int BUF_BYTES   = 256,
  parameter int BUF_BASE    = 'h600,
  parameter int FLAGS_ADDR  = 'h700,
  parameter int ENABLE_ADDR = 'h780,
  parameter logic [15:0] UNLOCK_KEY = 16'hC0DE,
  parameter logic [15:0] ID_WORD    = 16'h1DEA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_wait,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [2:0]        out_sev,
  output logic              out_last
);

  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int WORDS  = BUF_BYTES / 2;
  localparam int WIDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(BUF_BYTES - 1);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_STREAM, S_CLEAR} state_t;

  state_t            st;
  logic [7:0]        mem [BUF_BYTES];
  logic              unlocked;
  logic              err;
  logic [IDX_W-1:0]  rd_idx;
  logic [WIDX_W-1:0] clr_idx;
  logic [2:0]        sev_q;
  logic [2:0]        sev_map;

  logic [ADDR_W-1:0] boff;
  logic              hit_buf, hit_flags, hit_en, wr_ok, send_req;
  logic [IDX_W-1:0]  widx;
  logic [7:0]        cur_byte, nxt_byte;

  assign boff      = bus_addr - ADDR_W'(BUF_BASE);
  assign hit_buf   = boff < ADDR_W'(BUF_BYTES);
  assign hit_flags = bus_addr == ADDR_W'(FLAGS_ADDR);
  assign hit_en    = bus_addr == ADDR_W'(ENABLE_ADDR);
  assign widx      = boff[IDX_W-1:0];

  assign busy     = st != S_IDLE;
  assign bus_wait = bus_sel & bus_we & busy & (hit_buf | hit_flags);
  assign wr_ok    = bus_sel & bus_we & ~bus_wait;
  assign send_req = wr_ok & hit_flags & unlocked & bus_wdata[8];

  always_comb begin
    case (bus_wdata[3:0])
      4'd0, 4'd1: sev_map = 3'd1;
      4'd2:       sev_map = 3'd2;
      4'd3:       sev_map = 3'd3;
      4'd4:       sev_map = 3'd4;
      default:    sev_map = 3'd0;
    endcase
  end

  assign cur_byte  = mem[rd_idx];
  assign nxt_byte  = (rd_idx == LAST_IDX) ? 8'h00 : mem[IDX_W'(rd_idx + 1'b1)];
  assign out_valid = (st == S_STREAM) && (cur_byte != 8'h00);
  assign out_data  = cur_byte;
  assign out_sev   = sev_q;
  assign out_last  = (rd_idx == LAST_IDX) || (nxt_byte == 8'h00);

  always_comb begin
    bus_rdata = 16'h0000;
    if (bus_sel && !bus_we) begin
      if (hit_en)         bus_rdata = unlocked ? ID_WORD : 16'h0000;
      else if (hit_flags) bus_rdata = {err, 15'h0000};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      unlocked <= 1'b0;
      err      <= 1'b0;
      rd_idx   <= '0;
      clr_idx  <= '0;
      sev_q    <= 3'd0;
    end else begin
      if (wr_ok && hit_en) unlocked <= (bus_wdata == UNLOCK_KEY);
      case (st)
        S_IDLE: if (send_req) begin
          if (sev_map != 3'd0) begin
            st     <= S_STREAM;
            rd_idx <= '0;
            sev_q  <= sev_map;
          end else begin
            err <= 1'b1;
          end
        end
        S_STREAM: begin
          if (cur_byte == 8'h00 || (out_ready && out_last)) begin
            st      <= S_CLEAR;
            clr_idx <= '0;
          end else if (out_ready) begin
            rd_idx <= rd_idx + 1'b1;
          end
        end
        S_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST_WORD) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'h00;
    end else if (st == S_CLEAR) begin
      mem[{clr_idx, 1'b0}] <= 8'h00;
      mem[{clr_idx, 1'b1}] <= 8'h00;
    end else if (wr_ok && hit_buf) begin
      mem[widx] <= bus_wdata[7:0];
      if (widx != LAST_IDX) mem[IDX_W'(widx + 1'b1)] <= bus_wdata[15:8];
    end
  end

endmodule

// File: rtl/dbglog_port_chk.sv
module dbglog_port_chk #(
  parameter int ADDR_W      = 12,
  parameter int FLAGS_ADDR  = 'h700,
  parameter int ENABLE_ADDR = 'h780,
  parameter logic [15:0] UNLOCK_KEY = 16'hC0DE,
  parameter logic [15:0] ID_WORD    = 16'h1DEA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              bus_wait,
  input logic              busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [2:0]        out_sev,
  input logic              out_last
);

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sev) && $stable(out_last));

  a_r5_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  a_r5_last_ends_message: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  a_r9_wait_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> busy);

  a_r9_reads_never_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_we |-> !bus_wait);

  a_r1_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(ENABLE_ADDR) && bus_wdata == UNLOCK_KEY)
    ##1 (bus_sel && !bus_we && bus_addr == ADDR_W'(ENABLE_ADDR)) |-> bus_rdata == ID_WORD);

  a_r7_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && !busy && bus_addr == ADDR_W'(FLAGS_ADDR) && bus_wdata[8] && bus_wdata[3:0] > 4'd4
    |=> !busy);

  a_r8_no_send_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && !busy && bus_addr == ADDR_W'(FLAGS_ADDR) && !bus_wdata[8] |=> !busy);

endmodule

bind dbglog_port dbglog_port_chk #(
  .ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR), .ENABLE_ADDR(ENABLE_ADDR),
  .UNLOCK_KEY(UNLOCK_KEY), .ID_WORD(ID_WORD)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait), .busy(busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sev(out_sev),
  .out_last(out_last)
);

// File: tb/dbglog_port_tb.sv
module dbglog_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_wait, busy, out_valid, out_last;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [2:0]  out_sev;

  always #5 clk = ~clk;

  dbglog_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sev(out_sev),
    .out_last(out_last)
  );

  int    nchk = 0, nfail = 0, cyc = 0;
  string scn = "reset";
  int    rdy_mode = 0;

  int    mem_m [256];
  bit    unl = 0, errm = 0, strm = 0;
  int    clr_left = 0, sevm = 0;
  int    q [$];

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, scn, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      summary();
    end
    if (rst_n) begin
      bit hb, hf, he, eb, ew, ev;
      int er;
      hb = bus_addr >= 12'h600 && bus_addr < 12'h700;
      hf = bus_addr == 12'h700;
      he = bus_addr == 12'h780;
      eb = strm || clr_left > 0;
      ew = bus_sel && bus_we && eb && (hb || hf);
      er = 0;
      if (bus_sel && !bus_we) begin
        if (he) er = unl ? 16'h1DEA : 0;
        else if (hf) er = errm ? 16'h8000 : 0;
        chk(bus_rdata == 16'(er), "R1 R2 rdata", bus_rdata, er);
      end
      chk(busy == eb, "R9 R10 busy", busy, eb);
      chk(bus_wait == ew, "R9 bus_wait", bus_wait, ew);
      ev = strm && q.size() > 0;
      chk(out_valid == ev, "R5 out_valid", out_valid, ev);
      if (ev && out_valid) begin
        chk(out_data == 8'(q[0]), "R5 R3 out_data", out_data, q[0]);
        chk(out_sev == 3'(sevm), "R6 out_sev", out_sev, sevm);
        chk(out_last == (q.size() == 1), "R5 out_last", out_last, q.size() == 1);
      end
      if (strm) begin
        if (q.size() == 0 || (out_ready && q.size() == 1)) begin
          q.delete();
          strm = 0;
          clr_left = 128;
          for (int i = 0; i < 256; i++) mem_m[i] = 0;
        end else if (out_ready) begin
          void'(q.pop_front());
        end
      end else if (clr_left > 0) begin
        clr_left--;
      end
      if (bus_sel && bus_we && !ew) begin
        if (he) unl = (bus_wdata == 16'hC0DE);
        else if (hb) begin
          int n;
          n = bus_addr - 12'h600;
          mem_m[n] = bus_wdata[7:0];
          if (n < 255) mem_m[n+1] = bus_wdata[15:8];
        end else if (hf && unl && bus_wdata[8]) begin
          int lv;
          lv = bus_wdata[3:0];
          if (lv > 4) errm = 1;
          else begin
            sevm = (lv <= 1) ? 1 : lv;
            for (int i = 0; i < 256; i++) begin
              if (mem_m[i] == 0) break;
              q.push_back(mem_m[i]);
            end
            strm = 1;
          end
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    forever begin
      @(negedge clk);
      if (!bus_wait) break;
    end
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic wait_idle;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [15:0] r;
    for (int i = 0; i < 256; i++) mem_m[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2: reset state
    @(negedge clk);
    chk(busy == 0 && out_valid == 0, "R2 reset idle", {busy, out_valid}, 0);
    rd(12'h780, r); chk(r == 0, "R2 reset closed", r, 0);

    // R4: closed port ignores send; R3 text writes land while closed
    scn = "R4 closed";
    wr(12'h600, 16'h4241);
    wr(12'h700, 16'h0103);
    repeat (4) @(negedge clk);
    chk(busy == 0, "R4 no send", busy, 0);

    // R1: key handling
    scn = "R1 key";
    wr(12'h780, 16'h1234);
    rd(12'h780, r); chk(r == 16'h0000, "R1 wrong key", r, 0);
    wr(12'h780, 16'hC0DE);
    rd(12'h780, r); chk(r == 16'h1DEA, "R1 opened", r, 16'h1DEA);
    rd(12'h600, r); chk(r == 0, "R2 text reads zero", r, 0);
    rd(12'h700, r); chk(r == 0, "R2 flags zero", r, 0);

    // R8: no send bit
    scn = "R8 no send";
    wr(12'h700, 16'h0003);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R8 silent", busy, 0);

    // R3 odd offset, R5 R6 info message with stalling sink R11
    scn = "R5 info";
    rdy_mode = 1;
    wr(12'h601, 16'h4443);
    wr(12'h700, 16'h0103);
    wait_idle();

    // R10: text area wiped, second send is empty
    scn = "R10 empty";
    wr(12'h700, 16'h0102);
    wait_idle();

    // R6: codes 1 and 2
    scn = "R6 code1";
    wr(12'h600, 16'h0051);
    wr(12'h700, 16'h0101);
    wait_idle();
    scn = "R6 code2";
    wr(12'h600, 16'h0057);
    wr(12'h700, 16'h0102);
    wait_idle();

    // R7: illegal code
    scn = "R7 bad code";
    wr(12'h600, 16'h4949);
    wr(12'h700, 16'h0107);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R7 no stream", busy, 0);
    rd(12'h700, r); chk(r == 16'h8000, "R7 sticky flag", r, 16'h8000);

    // R5 full 256 bytes, R3 high byte at 255 dropped, code 0; R9 holds during stream
    scn = "R5 full";
    for (int k = 0; k < 128; k++)
      wr(12'(12'h600 + 2 * k), {8'((2 * k + 1) % 255 + 1), 8'((2 * k) % 255 + 1)});
    wr(12'h6FF, 16'hAA77);
    wr(12'h700, 16'h0100);
    scn = "R9 overlap";
    wr(12'h780, 16'hC0DE);
    chk(busy == 1, "R9 key write passes while busy", busy, 1);
    wr(12'h600, 16'h5A5A);
    chk(busy == 0, "R9 text write held to idle", busy, 0);
    scn = "R6 code4";
    wr(12'h700, 16'h0104);
    wait_idle();
    rd(12'h700, r); chk(r == 16'h8000, "R7 flag still set", r, 16'h8000);

    summary();
  end
endmodule